// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the host write cycles that reach a parallel flash array and recognises the multi-cycle command sequences in them. A recognised program sequence produces a one-cycle program request that carries the target address and data to the program engine. The block also tracks two persistent modes. The first is a fast-program mode that drops the unlock pair. The second is a mode that maps accesses onto a secured serial-number area.

Each write is presented for one clock with `wr_en` high. Command bytes are taken from the low eight data bits. Command addresses are compared on the low eleven address bits only, so higher address bits play no part in decoding. An `accel` input stands for the accelerated-programming condition and pushes the decoder into fast-program mode. The two modes never hold at the same time.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and right after it is released, `prog_req`, `bypass_mode` and `secure_mode` are 0. A sequence that was partly entered before reset is forgotten.
- R2: In read mode, a program is four writes: AAh at 555h, then 55h at 2AAh, then A0h at 555h, then the target write. One cycle after the target write, `prog_req` is 1 and `prog_addr`/`prog_data` hold that write's address and data.
- R3: Command addresses are decoded on address bits [10:0] only. A write with wrong data or a wrong address at any step of the unlock pair or command step returns the decoder to read mode, and no request follows.
- R4: AAh at 555h, then 55h at 2AAh, then 20h at 555h, sets `bypass_mode` one cycle after the third write.
- R5: In fast-program mode, a write of A0h at any address followed by a target write raises `prog_req` with that target. The pair may be repeated any number of times.
- R6: In fast-program mode, every write other than the A0h program prefix and the 90h reset prefix is ignored. `secure_mode` stays 0 and the mode is kept.
- R7: Fast-program mode is left by 90h followed by 00h, at any addresses. If the write after 90h is not 00h, the decoder stays in fast-program mode.
- R8: With `accel` high and `secure_mode` low, `bypass_mode` is 1 on the next cycle. While `accel` stays high, the 90h/00h exit has no effect. Dropping `accel` does not leave the mode.
- R9: AAh at 555h, then 55h at 2AAh, then 88h at 555h, sets `secure_mode`.
- R10: `secure_mode` is cleared by AAh at 555h, then 55h at 2AAh, then 90h at 555h, then 00h at any address. A non-zero fourth write leaves it set.
- R11: While `secure_mode` is 1, the 20h entry command and `accel` do not set `bypass_mode`.
- R12: `prog_req` is never high for two cycles in a row, and it only follows a clock in which `wr_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; command byte in bits [7:0] |
| accel | input | 1 | Logical accelerated-programming request |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address for the program request |
| prog_data | output | DATA_W | Data for the program request |
| bypass_mode | output | 1 | Fast-program mode active |
| secure_mode | output | 1 | Secured-region mode active |

## Verification
The bench builds the decoder with ADDR_W = 16 and DATA_W = 16, which is wider than the defaults. Unlock writes at addresses such as F555h then show that bits above [10:0] are ignored in decoding. Program targets such as BEEFh show that the full data word is carried past the command byte. The widths also allow target addresses and data whose low byte looks like a command, to show that a target write is never decoded as one.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accel,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              bypass_mode,
  output logic              secure_mode
);
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;

  typedef enum logic [2:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG, S_SEXIT, S_BIDLE, S_BPROG, S_BRST
  } st_t;

  st_t st;
  logic bypass_q, secure_q;

  wire [7:0] cmd  = wr_data[7:0];
  wire       at_a = (wr_addr[CMD_AW-1:0] == ADR_A);
  wire       at_b = (wr_addr[CMD_AW-1:0] == ADR_B);
  wire       force_bp = accel && !secure_q && !bypass_q;

  assign bypass_mode = bypass_q;
  assign secure_mode = secure_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_READ;
      bypass_q  <= 1'b0;
      secure_q  <= 1'b0;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_req <= 1'b0;
      if (force_bp) begin
        bypass_q <= 1'b1;
        st       <= S_BIDLE;
      end else if (wr_en) begin
        case (st)
          S_READ: if (cmd == 8'hAA && at_a) st <= S_UNL1;
          S_UNL1: st <= (cmd == 8'h55 && at_b) ? S_UNL2 : S_READ;
          S_UNL2: begin
            st <= S_READ;
            if (at_a) begin
              case (cmd)
                8'hA0: st <= S_PROG;
                8'h20: if (!secure_q) begin
                  bypass_q <= 1'b1;
                  st       <= S_BIDLE;
                end
                8'h88: secure_q <= 1'b1;
                8'h90: if (secure_q) st <= S_SEXIT;
                default: ;
              endcase
            end
          end
          S_PROG, S_BPROG: begin
            prog_req  <= 1'b1;
            prog_addr <= wr_addr;
            prog_data <= wr_data;
            st        <= (st == S_PROG) ? S_READ : S_BIDLE;
          end
          S_SEXIT: begin
            if (cmd == 8'h00) secure_q <= 1'b0;
            st <= S_READ;
          end
          S_BIDLE: begin
            if (cmd == 8'hA0) st <= S_BPROG;
            else if (cmd == 8'h90) st <= S_BRST;
          end
          S_BRST: begin
            if (cmd == 8'h00 && !accel) begin
              bypass_q <= 1'b0;
              st       <= S_READ;
            end else begin
              st <= S_BIDLE;
            end
          end
          default: st <= S_READ;
        endcase
      end
    end
  end

  // R6 R11
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass_mode && secure_mode));

  // R8
  accel_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accel && !secure_mode && !bypass_mode) |=> bypass_mode);

  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  // R12
  req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wr_en));

  // R7
  bypass_exit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_mode) |-> $past(wr_en));

  // R9
  secure_entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure_mode) |-> $past(wr_en));
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic accel = 1'b0;
  logic prog_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic bypass_mode, secure_mode;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .accel(accel), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .bypass_mode(bypass_mode), .secure_mode(secure_mode));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1 req in reset", prog_req, 0);
    chk("R1 bypass in reset", bypass_mode, 0);
    chk("R1 secure in reset", secure_mode, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 bypass after release", bypass_mode, 0);
    unlock();
    do_reset();
    wr(16'h0555, 16'h00A0);
    wr(16'h0300, 16'h1111);
    chk("R1 partial sequence dropped", prog_req, 0);
  endtask

  task automatic t_std_prog();
    wr(16'hF555, 16'h00AA);
    wr(16'hF2AA, 16'h0055);
    wr(16'h0555, 16'h00A0);
    chk("R2 no req before target", prog_req, 0);
    wr(16'h1234, 16'hBEEF);
    chk("R2 req", prog_req, 1);
    chk("R2 addr", prog_addr, 16'h1234);
    chk("R2 data", prog_data, 16'hBEEF);
    chk("R3 high addr bits ignored", prog_req, 1);
    idle(1);
    chk("R12 single pulse", prog_req, 0);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
    wr(16'h0555, 16'h00AA);
    chk("R2 target not decoded", prog_req, 1);
    chk("R2 target data", prog_data, 16'h00AA);
  endtask

  task automatic t_bad_unlock();
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0054);
    wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h1111);
    chk("R3 wrong unlock data", prog_req, 0);
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055);
    wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h1111);
    chk("R3 wrong unlock address", prog_req, 0);
    unlock(); wr(16'h0556, 16'h00A0); wr(16'h0100, 16'h1111);
    chk("R3 wrong command address", prog_req, 0);
    idle(1);
    chk("R12 no stray req", prog_req, 0);
  endtask

  task automatic t_bypass();
    unlock(); wr(16'h0555, 16'h0020);
    chk("R4 bypass entered", bypass_mode, 1);
    wr(16'h7777, 16'h00A0); wr(16'h0042, 16'h1357);
    chk("R5 req 1", prog_req, 1);
    chk("R5 addr 1", prog_addr, 16'h0042);
    chk("R5 data 1", prog_data, 16'h1357);
    wr(16'h0000, 16'h00A0); wr(16'h0043, 16'h2468);
    chk("R5 req 2", prog_req, 1);
    chk("R5 data 2", prog_data, 16'h2468);
    unlock(); wr(16'h0555, 16'h0088);
    chk("R6 secure entry ignored", secure_mode, 0);
    chk("R6 bypass kept", bypass_mode, 1);
    chk("R6 no req", prog_req, 0);
    wr(16'h0001, 16'h00A0); wr(16'h0044, 16'h5555);
    chk("R6 state intact", prog_req, 1);
    wr(16'h0001, 16'h0090); wr(16'h0001, 16'h0055);
    chk("R7 bad second reset write", bypass_mode, 1);
    wr(16'h0001, 16'h0090); wr(16'h0002, 16'h0000);
    chk("R7 exit", bypass_mode, 0);
    wr(16'h0000, 16'h00A0); wr(16'h0005, 16'h0005);
    chk("R7 back in read mode", prog_req, 0);
  endtask

  task automatic t_accel();
    @(negedge clk); accel = 1'b1;
    @(negedge clk);
    chk("R8 accel forces bypass", bypass_mode, 1);
    wr(16'h0001, 16'h0090); wr(16'h0001, 16'h0000);
    chk("R8 exit blocked with accel", bypass_mode, 1);
    accel = 1'b0;
    idle(1);
    chk("R8 mode kept after accel drop", bypass_mode, 1);
    wr(16'h0001, 16'h0090); wr(16'h0001, 16'h0000);
    chk("R7 exit after accel", bypass_mode, 0);
  endtask

  task automatic t_secure();
    unlock(); wr(16'h0555, 16'h0088);
    chk("R9 secure entered", secure_mode, 1);
    unlock(); wr(16'h0555, 16'h0020);
    chk("R11 bypass entry blocked", bypass_mode, 0);
    @(negedge clk); accel = 1'b1;
    idle(2);
    chk("R11 accel blocked", bypass_mode, 0);
    accel = 1'b0;
    unlock(); wr(16'h0555, 16'h0090); wr(16'h0000, 16'h0001);
    chk("R10 non-zero keeps secure", secure_mode, 1);
    unlock(); wr(16'h0555, 16'h0090); wr(16'h0ABC, 16'h0000);
    chk("R10 secure exit", secure_mode, 0);
    unlock(); wr(16'h0555, 16'h0020);
    chk("R4 bypass after secure exit", bypass_mode, 1);
    do_reset();
    idle(1);
    chk("R1 reset clears bypass", bypass_mode, 0);
  endtask

  initial begin
    t_reset();
    t_std_prog();
    t_bad_unlock();
    t_bypass();
    t_accel();
    t_secure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule